// File: doc/BRIEF.md
# Raster Interrupt and DMA Trigger Unit

This unit sits beside a video timing generator and turns raster positions into events. On every cycle where `eval` is high it looks at the current line, dot position and horizontal cycle count. It then picks at most one of three requests: a horizontal-blank DMA request, a non-maskable interrupt request, or a maskable raster interrupt request. Each request is a one-cycle pulse one clock after the evaluation.

The unit holds a one-shot DMA latch that is re-armed at each line, and an NMI-triggered latch that is re-armed at each frame. It also drives internal NMI and IRQ lines that go low when an interrupt is taken and come back high at line or frame boundaries. At the start of the configured poll line, with auto-poll enabled, it emits a poll pulse and loads the controller read position.

The evaluation decision is a small state machine of type `rt_event_t`. Its states are:
- `EV_NONE`: no event.
- `EV_DMA`: DMA request.
- `EV_NMI`: NMI request.
- `EV_IRQ`: IRQ request.

Every cycle the next state is taken from the current inputs:
- `EV_DMA` when the DMA condition holds.
- Otherwise `EV_NMI` when the NMI condition holds and NMI is enabled.
- Otherwise `EV_IRQ` when the IRQ condition holds.
- Otherwise `EV_NONE`. A boundary cycle, or a cycle without `eval`, always returns the machine to `EV_NONE`.

The output process decodes the state register into the three request pulses.

Top module: `raster_evt_unit`

## Requirements
- R1: An evaluation with `vline < vis_lines`, `hdot >= 278` and the DMA latch clear gives `dma_req` high for one cycle on the next clock and sets the latch. Further DMA conditions are ignored until a line or frame start clears the latch.
- R2: The NMI condition holds when `vline == vis_lines+1` and `hcyc >= 12`, or when `vline > vis_lines+1`. When it holds during an evaluation with `nmi_trig` low (and no DMA event is taken), `nmi_trig` goes high and `nmi_line` goes low on the next clock. This happens at most once per frame.
- R3: `nmi_req` pulses for that evaluation only when `nmi_en` is 1. When `nmi_en` is 0, R2 still happens and the evaluation may go on to an IRQ.
- R4: The raster IRQ condition depends on the enables:
  - `virq_en=1` and `hirq_en=1`: `vline == vtarget` and `hdot >= htarget`.
  - `virq_en=1` only: `vline == vtarget`.
  - `hirq_en=1` only: `hdot >= htarget`.
  - Neither enabled: never true.
  It is considered only while `irq_mask` is 0.
- R5: An IRQ fires only while `irq_line` is high. Firing gives an `irq_req` pulse on the next clock, sets `irq_trig` and drives `irq_line` low.
- R6: `irq_line` returns high at every `line_start` while `virq_en` is 0, and at every `frame_start`.
- R7: Priority is DMA, then NMI, then IRQ, with at most one request per evaluation. While `dma_busy` is 1, NMI and IRQ evaluation is suspended and no latch or line changes. A cycle with `line_start` or `frame_start` performs no evaluation.
- R8: `frame_start` has the following effects:
  - clears `nmi_trig`, `irq_trig`, `stat_read` and the DMA latch;
  - sets `nmi_line` and `irq_line` high;
  - clear wins over a same-cycle `status_rd`.
- R9: A `line_start` with `vline == 225` and `autopoll_en` high gives `poll_pulse` for one cycle on the next clock and loads `pad_pos` with 16. Otherwise `pad_pos` holds.
- R10: After reset:
  - all request pulses and `poll_pulse` are low;
  - `nmi_line` and `irq_line` are high;
  - `nmi_trig`, `irq_trig` and `stat_read` are low;
  - `pad_pos` is 0.
- R11: `status_rd` sets `stat_read` on the next clock. It stays set until a frame start or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval | input | 1 | Evaluate raster position this cycle |
| line_start | input | 1 | Start of a new line |
| frame_start | input | 1 | Start of a new frame |
| vline | input | 9 | Current line |
| hdot | input | 9 | Current horizontal dot position |
| hcyc | input | 11 | Horizontal cycle count within the line |
| vis_lines | input | 9 | Number of visible lines |
| vtarget | input | 9 | Vertical IRQ compare line |
| htarget | input | 9 | Horizontal IRQ compare dot |
| nmi_en | input | 1 | NMI request enable |
| virq_en | input | 1 | Vertical compare enable |
| hirq_en | input | 1 | Horizontal compare enable |
| irq_mask | input | 1 | Processor interrupt-disable flag |
| dma_busy | input | 1 | DMA transfer in progress |
| autopoll_en | input | 1 | Controller auto-poll enable |
| status_rd | input | 1 | Status read strobe |
| dma_req | output | 1 | Horizontal-blank DMA request pulse |
| nmi_req | output | 1 | NMI request pulse |
| irq_req | output | 1 | IRQ request pulse |
| nmi_line | output | 1 | Internal NMI line, low after NMI condition |
| irq_line | output | 1 | Internal IRQ line, low after IRQ taken |
| nmi_trig | output | 1 | NMI-triggered latch |
| irq_trig | output | 1 | IRQ-triggered flag |
| stat_read | output | 1 | Status-read flag |
| poll_pulse | output | 1 | Auto-poll pulse |
| pad_pos | output | 5 | Controller read position |

## Verification
The bench targets the NMI threshold exactly at `hcyc` 11 and 12 on the first line past the visible area. An off-by-one comparison would raise the NMI a cycle early or late there. It also targets evaluations where the NMI condition holds with NMI disabled: a design that stopped there would drop the IRQ, while one that skipped the latch would fire the NMI again later in the frame. Random mixes of `dma_busy`, `line_start` and `frame_start` check two further points. A design that kept evaluating during a transfer would emit interrupts early. A design that re-armed `irq_line` at every line regardless of `virq_en` would raise repeated IRQs on the matching line.

// File: rtl/raster_pkg.sv
package raster_pkg;
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_DMA  = 2'd1,
        EV_NMI  = 2'd2,
        EV_IRQ  = 2'd3
    } rt_event_t;
endpackage

// File: rtl/raster_cmp.sv
module raster_cmp #(
    parameter int LW      = 9,
    parameter int DW      = 9,
    parameter int CW      = 11,
    parameter int DMA_DOT = 278,
    parameter int NMI_CYC = 12
) (
    input  logic [LW-1:0] vline,
    input  logic [DW-1:0] hdot,
    input  logic [CW-1:0] hcyc,
    input  logic [LW-1:0] vis_lines,
    input  logic [LW-1:0] vtarget,
    input  logic [DW-1:0] htarget,
    input  logic          virq_en,
    input  logic          hirq_en,
    output logic          dma_hit,
    output logic          nmi_hit,
    output logic          irq_hit
);
    localparam int LX = LW + 1;

    logic [LX-1:0] line_ext;
    logic [LX-1:0] first_blank;

    assign line_ext    = {1'b0, vline};
    assign first_blank = {1'b0, vis_lines} + LX'(1);

    // horizontal-blank transfer window on visible lines only
    assign dma_hit = (vline < vis_lines) && (hdot >= DW'(DMA_DOT));

    // vertical blank entry with a cycle offset on its first line
    assign nmi_hit = ((line_ext == first_blank) && (hcyc >= CW'(NMI_CYC)))
                   || (line_ext > first_blank);

    always_comb begin
        unique case ({virq_en, hirq_en})
            2'b11:   irq_hit = (vline == vtarget) && (hdot >= htarget);
            2'b10:   irq_hit = (vline == vtarget);
            2'b01:   irq_hit = (hdot >= htarget);
            default: irq_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/raster_ctl.sv
module raster_ctl
    import raster_pkg::*;
#(
    parameter int LW        = 9,
    parameter int PW        = 5,
    parameter int POLL_LINE = 225,
    parameter int PAD_LOAD  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eval,
    input  logic          line_start,
    input  logic          frame_start,
    input  logic [LW-1:0] vline,
    input  logic          dma_hit,
    input  logic          nmi_hit,
    input  logic          irq_hit,
    input  logic          nmi_en,
    input  logic          virq_en,
    input  logic          irq_mask,
    input  logic          dma_busy,
    input  logic          autopoll_en,
    input  logic          status_rd,
    output logic          dma_req,
    output logic          nmi_req,
    output logic          irq_req,
    output logic          nmi_line,
    output logic          irq_line,
    output logic          nmi_trig,
    output logic          irq_trig,
    output logic          stat_read,
    output logic          poll_pulse,
    output logic [PW-1:0] pad_pos
);
    rt_event_t ev_q, ev_nx;
    logic      take_nmi;
    logic      dma_done;
    logic      boundary;

    assign boundary = line_start || frame_start;

    // next-event decision: DMA, then NMI, then IRQ
    always_comb begin
        ev_nx    = EV_NONE;
        take_nmi = 1'b0;
        if (!boundary && eval) begin
            if (dma_hit && !dma_done) begin
                ev_nx = EV_DMA;
            end else if (!dma_busy) begin
                if (nmi_hit && !nmi_trig) begin
                    take_nmi = 1'b1;
                    if (nmi_en) ev_nx = EV_NMI;
                end
                if (ev_nx == EV_NONE && !irq_mask && irq_hit && irq_line)
                    ev_nx = EV_IRQ;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= EV_NONE;
        else        ev_q <= ev_nx;
    end

    // latches and interrupt lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_done   <= 1'b0;
            nmi_trig   <= 1'b0;
            irq_trig   <= 1'b0;
            nmi_line   <= 1'b1;
            irq_line   <= 1'b1;
            stat_read  <= 1'b0;
            poll_pulse <= 1'b0;
            pad_pos    <= '0;
        end else begin
            poll_pulse <= 1'b0;
            if (status_rd) stat_read <= 1'b1;
            if (line_start) begin
                dma_done <= 1'b0;
                if (!virq_en) irq_line <= 1'b1;
                if (autopoll_en && (vline == LW'(POLL_LINE))) begin
                    poll_pulse <= 1'b1;
                    pad_pos    <= PW'(PAD_LOAD);
                end
            end
            if (frame_start) begin
                dma_done  <= 1'b0;
                nmi_trig  <= 1'b0;
                irq_trig  <= 1'b0;
                stat_read <= 1'b0;
                nmi_line  <= 1'b1;
                irq_line  <= 1'b1;
            end
            if (ev_nx == EV_DMA) dma_done <= 1'b1;
            if (take_nmi) begin
                nmi_trig <= 1'b1;
                nmi_line <= 1'b0;
            end
            if (ev_nx == EV_IRQ) begin
                irq_trig <= 1'b1;
                irq_line <= 1'b0;
            end
        end
    end

    // output decode
    always_comb begin
        dma_req = 1'b0;
        nmi_req = 1'b0;
        irq_req = 1'b0;
        unique case (ev_q)
            EV_DMA:  dma_req = 1'b1;
            EV_NMI:  nmi_req = 1'b1;
            EV_IRQ:  irq_req = 1'b1;
            default: ;
        endcase
    end

    assert_dma_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> $past(dma_hit) && $past(eval));

    assert_nmi_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_trig) |-> !nmi_line);

    assert_nmi_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> $past(nmi_en) && !nmi_line);

    assert_irq_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(irq_line) && !irq_line && irq_trig);

    assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req || irq_req) |-> !$past(dma_busy));

    assert_frame_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_start) |-> !nmi_trig && !stat_read && nmi_line && irq_line);

    assert_poll_R9: assert property (@(posedge clk) disable iff (!rst_n)
        poll_pulse |-> pad_pos == PW'(PAD_LOAD));
endmodule

// File: rtl/raster_evt_unit.sv
module raster_evt_unit #(
    parameter int LW        = 9,
    parameter int DW        = 9,
    parameter int CW        = 11,
    parameter int PW        = 5,
    parameter int DMA_DOT   = 278,
    parameter int NMI_CYC   = 12,
    parameter int POLL_LINE = 225,
    parameter int PAD_LOAD  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eval,
    input  logic          line_start,
    input  logic          frame_start,
    input  logic [LW-1:0] vline,
    input  logic [DW-1:0] hdot,
    input  logic [CW-1:0] hcyc,
    input  logic [LW-1:0] vis_lines,
    input  logic [LW-1:0] vtarget,
    input  logic [DW-1:0] htarget,
    input  logic          nmi_en,
    input  logic          virq_en,
    input  logic          hirq_en,
    input  logic          irq_mask,
    input  logic          dma_busy,
    input  logic          autopoll_en,
    input  logic          status_rd,
    output logic          dma_req,
    output logic          nmi_req,
    output logic          irq_req,
    output logic          nmi_line,
    output logic          irq_line,
    output logic          nmi_trig,
    output logic          irq_trig,
    output logic          stat_read,
    output logic          poll_pulse,
    output logic [PW-1:0] pad_pos
);
    logic dma_hit, nmi_hit, irq_hit;

    raster_cmp #(
        .LW(LW), .DW(DW), .CW(CW), .DMA_DOT(DMA_DOT), .NMI_CYC(NMI_CYC)
    ) u_cmp (
        .vline(vline), .hdot(hdot), .hcyc(hcyc), .vis_lines(vis_lines),
        .vtarget(vtarget), .htarget(htarget),
        .virq_en(virq_en), .hirq_en(hirq_en),
        .dma_hit(dma_hit), .nmi_hit(nmi_hit), .irq_hit(irq_hit)
    );

    raster_ctl #(
        .LW(LW), .PW(PW), .POLL_LINE(POLL_LINE), .PAD_LOAD(PAD_LOAD)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .eval(eval),
        .line_start(line_start), .frame_start(frame_start), .vline(vline),
        .dma_hit(dma_hit), .nmi_hit(nmi_hit), .irq_hit(irq_hit),
        .nmi_en(nmi_en), .virq_en(virq_en), .irq_mask(irq_mask),
        .dma_busy(dma_busy), .autopoll_en(autopoll_en), .status_rd(status_rd),
        .dma_req(dma_req), .nmi_req(nmi_req), .irq_req(irq_req),
        .nmi_line(nmi_line), .irq_line(irq_line),
        .nmi_trig(nmi_trig), .irq_trig(irq_trig), .stat_read(stat_read),
        .poll_pulse(poll_pulse), .pad_pos(pad_pos)
    );
endmodule

// File: tb/sim_raster_evt_unit.sv
`timescale 1ns/1ps
module sim_raster_evt_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eval = 0, line_start = 0, frame_start = 0;
    logic [8:0] vline = 0, hdot = 0, vis_lines = 9'd224, vtarget = 0, htarget = 0;
    logic [10:0] hcyc = 0;
    logic nmi_en = 0, virq_en = 0, hirq_en = 0, irq_mask = 0, dma_busy = 0;
    logic autopoll_en = 0, status_rd = 0;
    logic dma_req, nmi_req, irq_req, nmi_line, irq_line, nmi_trig, irq_trig;
    logic stat_read, poll_pulse;
    logic [4:0] pad_pos;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // bench expectation state
    bit m_done, m_ntrig, m_itrig, m_nline, m_iline, m_rd, m_poll;
    bit m_dreq, m_nreq, m_ireq;
    logic [4:0] m_pad;

    always #4 clk = ~clk;

    raster_evt_unit u0 (
        .clk(clk), .rst_n(rst_n), .eval(eval), .line_start(line_start),
        .frame_start(frame_start), .vline(vline), .hdot(hdot), .hcyc(hcyc),
        .vis_lines(vis_lines), .vtarget(vtarget), .htarget(htarget),
        .nmi_en(nmi_en), .virq_en(virq_en), .hirq_en(hirq_en),
        .irq_mask(irq_mask), .dma_busy(dma_busy), .autopoll_en(autopoll_en),
        .status_rd(status_rd), .dma_req(dma_req), .nmi_req(nmi_req),
        .irq_req(irq_req), .nmi_line(nmi_line), .irq_line(irq_line),
        .nmi_trig(nmi_trig), .irq_trig(irq_trig), .stat_read(stat_read),
        .poll_pulse(poll_pulse), .pad_pos(pad_pos)
    );

    function automatic bit f_dma();
        return (vline < vis_lines) && (hdot >= 9'd278);
    endfunction

    function automatic bit f_nmi();
        int fb = int'(vis_lines) + 1;
        return (int'(vline) == fb && hcyc >= 11'd12) || int'(vline) > fb;
    endfunction

    function automatic bit f_irq();
        if (virq_en && hirq_en) return (vline == vtarget) && (hdot >= htarget);
        if (virq_en)            return vline == vtarget;
        if (hirq_en)            return hdot >= htarget;
        return 1'b0;
    endfunction

    task automatic m_reset();
        m_done = 0; m_ntrig = 0; m_itrig = 0; m_nline = 1; m_iline = 1;
        m_rd = 0; m_poll = 0; m_pad = 0; m_dreq = 0; m_nreq = 0; m_ireq = 0;
    endtask

    task automatic m_update();
        bit d = 0, n = 0, i = 0, tk = 0;
        bit bnd = line_start || frame_start;
        if (!bnd && eval) begin
            if (f_dma() && !m_done) d = 1;
            else if (!dma_busy) begin
                if (f_nmi() && !m_ntrig) begin tk = 1; n = nmi_en; end
                if (!n && !irq_mask && f_irq() && m_iline) i = 1;
            end
        end
        m_poll = 0;
        if (status_rd) m_rd = 1;
        if (line_start) begin
            m_done = 0;
            if (!virq_en) m_iline = 1;
            if (autopoll_en && vline == 9'd225) begin m_poll = 1; m_pad = 5'd16; end
        end
        if (frame_start) begin
            m_done = 0; m_ntrig = 0; m_itrig = 0; m_rd = 0; m_nline = 1; m_iline = 1;
        end
        if (d) m_done = 1;
        if (tk) begin m_ntrig = 1; m_nline = 0; end
        if (i) begin m_itrig = 1; m_iline = 0; end
        m_dreq = d; m_nreq = n; m_ireq = i;
    endtask

    task automatic chk(input logic got, input bit exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(dma_req,    m_dreq,  "R1 dma_req");
        chk(nmi_trig,   m_ntrig, "R2 nmi_trig");
        chk(nmi_line,   m_nline, "R2 nmi_line");
        chk(nmi_req,    m_nreq,  "R3 nmi_req");
        chk(irq_req,    m_ireq,  "R4 R5 irq_req");
        chk(irq_trig,   m_itrig, "R5 irq_trig");
        chk(irq_line,   m_iline, "R6 irq_line");
        chk(stat_read,  m_rd,    "R11 stat_read");
        chk(poll_pulse, m_poll,  "R9 poll_pulse");
        n_chk++;
        if (pad_pos !== m_pad) begin
            n_bad++;
            $display("FAIL R9 pad_pos: got %0d expected %0d", pad_pos, m_pad);
        end
    endtask

    task automatic step();
        @(posedge clk);
        if (rst_n) m_update(); else m_reset();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        eval = 0; line_start = 0; frame_start = 0; status_rd = 0; dma_busy = 0;
    endtask

    initial begin
        int blk_vis;
        void'($urandom(32'd20240611));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state before any stimulus
        compare_all();
        step();

        // directed: NMI threshold (R2, R3), both sides of the cycle offset
        nmi_en = 1; vis_lines = 9'd224;
        frame_start = 1; step(); idle_inputs();
        eval = 1; vline = 9'd225; hdot = 9'd10; hcyc = 11'd11; step(); // R2 no NMI yet
        hcyc = 11'd12; step();                                           // R2 R3 NMI
        step();                                                          // R2 once per frame
        // R3: disabled NMI still latches, IRQ may follow in the same evaluation
        idle_inputs(); frame_start = 1; step(); idle_inputs();
        nmi_en = 0; hirq_en = 1; htarget = 0; eval = 1; vline = 9'd230; step();
        // R7: busy suspends interrupts, DMA still served
        idle_inputs(); frame_start = 1; step(); idle_inputs();
        dma_busy = 1; eval = 1; vline = 9'd10; hdot = 9'd300; step();
        step();
        // R1: boundary re-arm, R9 poll line
        idle_inputs(); line_start = 1; autopoll_en = 1; vline = 9'd225; step();
        idle_inputs(); eval = 1; vline = 9'd10; hdot = 9'd278; step();
        hdot = 9'd277; line_start = 1; eval = 0; step();
        idle_inputs(); eval = 1; step();
        idle_inputs(); step();

        // constrained random mix
        blk_vis = 224;
        for (int blk = 0; blk < 24; blk++) begin
            blk_vis     = ($urandom % 2 == 0) ? 224 : 239;
            vis_lines   = 9'(blk_vis);
            nmi_en      = 1'($urandom % 2);
            virq_en     = 1'($urandom % 2);
            hirq_en     = 1'($urandom % 2);
            autopoll_en = 1'($urandom % 2);
            for (int c = 0; c < 250; c++) begin
                eval        = 1'($urandom % 2);
                line_start  = ($urandom % 12 == 0);
                frame_start = ($urandom % 50 == 0);
                vline       = ($urandom % 3 == 0) ? 9'(blk_vis + int'($urandom % 3))
                                                  : 9'($urandom % 263);
                hdot        = 9'($urandom % 341);
                hcyc        = 11'($urandom % 24);
                vtarget     = ($urandom % 3 == 0) ? vline : 9'($urandom % 263);
                htarget     = 9'($urandom % 341);
                irq_mask    = ($urandom % 4 == 0);
                dma_busy    = ($urandom % 5 == 0);
                status_rd   = ($urandom % 20 == 0);
                step();
            end
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule